// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 32-bit physical address by reading a two-level page table from memory. A requester presents an address and an access type (read, write or execute). The walker takes the top ten address bits as an index into a first-level directory. The base of that directory comes from a root register input, which is captured when the request is accepted. The directory entry gives the base of a second-level table. The middle ten address bits index that table to reach the leaf entry. The leaf entry's valid and permission bits decide the outcome.

On success the physical address is the leaf's page number joined to the unchanged 12-bit page offset. The response also carries the leaf's cache-disable bit. An invalid entry at either level ends the walk with a page fault. An access type that the leaf does not permit ends it with a protection fault. On success the walker sets the referenced bit in the leaf, and on a write it also sets the modified bit. It writes the leaf back to memory only when one of these bits actually changes.

Memory is reached through one word-addressed port, with at most one access outstanding. Each access completes when the memory raises an acknowledge, so any memory latency is accepted.

Top module: `pt_walker`

## Requirements
- R1: The first memory read of a walk goes to word address root_base/4 + va[31:22], where root_base is sampled when the request is accepted.
- R2: The second read goes to word address (pde[31:12] * 1024) + va[21:12], where pde is the directory entry just read. Only bit 0 and bits 31:12 of the directory entry are used.
- R3: The entry layout at both levels is: bit 0 valid, bit 1 read allowed, bit 2 write allowed, bit 3 execute allowed, bit 4 referenced, bit 5 modified, bit 6 cache-disable, and bits 31:12 physical page number. The access codes are 0 read, 1 write, 2 execute and 3 reserved.
- R4: If bit 0 is clear in the directory entry or in the leaf, the response carries fault code 1 (page fault), a physical address of 0 and cache-disable 0. No further read and no write follow.
- R5: If the leaf is valid but its permission bit for the access type is clear, the response carries fault code 2 (protection fault), a physical address of 0 and no write-back. The reserved access code always gives a protection fault.
- R6: A successful walk responds with fault code 0, physical address {leaf[31:12], va[11:0]}, and cache-disable equal to leaf bit 6.
- R7: A successful walk sets the referenced bit. A write also sets the modified bit. The updated leaf is written to its own word address only if its value changed, and no memory write happens otherwise.
- R8: req_ready is high only while the walker is idle, and a request offered while it is low is ignored. rsp_valid is a single-cycle pulse that carries the physical address, fault code and cache-disable together.
- R9: mem_rd_req and mem_wr_req are never high together. A pending request holds its address stable until mem_ack.
- R10: After reset, req_ready is 1, and rsp_valid, mem_rd_req and mem_wr_req are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| root_base | input | 32 | Byte address of the first-level directory |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_va | input | 32 | Virtual address to translate |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 reserved |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_pa | output | 32 | Translated physical address, 0 on a fault |
| rsp_fault | output | 2 | 0 none, 1 page fault, 2 protection fault |
| rsp_nocache | output | 1 | Cache-disable bit of the leaf entry |
| mem_rd_req | output | 1 | Memory read request, held until acknowledged |
| mem_wr_req | output | 1 | Memory write request, held until acknowledged |
| mem_addr | output | 30 | Word address of the memory access |
| mem_wdata | output | 32 | Write data (updated leaf entry) |
| mem_rdata | input | 32 | Read data, valid together with mem_ack |
| mem_ack | input | 1 | Completes the pending memory access |

## Verification
The bench builds the walker with its default split of 10/10/12 bits over 32-bit addresses. The root, directory and table regions are placed in a 4096-word memory model inside the bench. The model's acknowledge latency can be changed between scenarios. A zero latency exercises back-to-back state changes on acknowledge. A longer latency holds requests open, which lets the bench offer a second request in the middle of a walk and watch the address stay stable. Because the entries are reused across scenarios, the bench can observe both leaf outcomes: a write-back when the referenced or modified bit changes, and no write-back when a repeated access leaves the leaf unchanged.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  // entry flag positions, shared by both table levels
  localparam int FLG_VALID = 0;
  localparam int FLG_RD    = 1;
  localparam int FLG_WR    = 2;
  localparam int FLG_EX    = 3;
  localparam int FLG_REF   = 4;
  localparam int FLG_MOD   = 5;
  localparam int FLG_NC    = 6;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_PAGE = 2'd1,
    FLT_PROT = 2'd2,
    FLT_UNUS = 2'd3
  } fault_e;

  typedef enum logic [2:0] {
    WS_IDLE,
    WS_DIR,
    WS_LEAF,
    WS_WB,
    WS_RSP
  } walk_st_e;

  // permission lookup for one access type
  function automatic logic acc_permitted(logic rd, logic wr, logic ex, acc_e acc);
    case (acc)
      ACC_READ:  return rd;
      ACC_WRITE: return wr;
      ACC_EXEC:  return ex;
      default:   return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/ptw_perm_check.sv
module ptw_perm_check
  import ptw_pkg::*;
#(
  parameter int E_W = 32
) (
  input  logic [E_W-1:0] entry,
  input  logic [1:0]     acc,
  output logic [1:0]     fault
);
  logic ok;

  always_comb begin
    ok = acc_permitted(entry[FLG_RD], entry[FLG_WR], entry[FLG_EX], acc_e'(acc));
    if (!entry[FLG_VALID])
      fault = FLT_PAGE;
    else if (!ok)
      fault = FLT_PROT;
    else
      fault = FLT_NONE;
  end
endmodule

// File: rtl/ptw_pte_update.sv
module ptw_pte_update
  import ptw_pkg::*;
#(
  parameter int E_W = 32
) (
  input  logic [E_W-1:0] entry,
  input  logic [1:0]     acc,
  output logic [E_W-1:0] entry_new,
  output logic           changed
);
  logic [E_W-1:0] set_mask;

  always_comb begin
    set_mask = '0;
    set_mask[FLG_REF] = 1'b1;
    set_mask[FLG_MOD] = (acc_e'(acc) == ACC_WRITE);
    entry_new = entry | set_mask;
    changed   = (entry_new != entry);
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int DIR_W = 10,
  parameter int TBL_W = 10,
  parameter int OFF_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PA_W-1:0]   root_base,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_va,
  input  logic [1:0]        req_acc,
  output logic              rsp_valid,
  output logic [PA_W-1:0]   rsp_pa,
  output logic [1:0]        rsp_fault,
  output logic              rsp_nocache,
  output logic              mem_rd_req,
  output logic              mem_wr_req,
  output logic [PA_W-3:0]   mem_addr,
  output logic [PA_W-1:0]   mem_wdata,
  input  logic [PA_W-1:0]   mem_rdata,
  input  logic              mem_ack
);
  localparam int WA_W  = PA_W - 2;
  localparam int PPN_W = PA_W - OFF_W;
  localparam int E_W   = PA_W;

  walk_st_e        st_q;
  logic [VA_W-1:0] va_q;
  logic [1:0]      acc_q;
  logic [PA_W-1:0] root_q;
  logic [E_W-1:0]  pde_q;
  logic [E_W-1:0]  pte_q;
  logic [PA_W-1:0] pa_q;
  logic [1:0]      fault_q;
  logic            nc_q;

  // address arithmetic kept in functions
  function automatic logic [WA_W-1:0] dir_word(logic [PA_W-1:0] root, logic [VA_W-1:0] va);
    return root[PA_W-1:2] + WA_W'(va[VA_W-1 -: DIR_W]);
  endfunction

  function automatic logic [WA_W-1:0] leaf_word(logic [E_W-1:0] pde, logic [VA_W-1:0] va);
    return {pde[E_W-1:OFF_W], {(OFF_W-2){1'b0}}} + WA_W'(va[OFF_W +: TBL_W]);
  endfunction

  function automatic logic [PA_W-1:0] make_pa(logic [E_W-1:0] pte, logic [VA_W-1:0] va);
    return {pte[E_W-1 -: PPN_W], va[OFF_W-1:0]};
  endfunction

  // named events for assertions
  logic accept_ev;
  logic ack_dir_ev;
  logic ack_leaf_ev;
  logic ack_wb_ev;
  assign accept_ev   = req_valid && req_ready;
  assign ack_dir_ev  = (st_q == WS_DIR)  && mem_ack;
  assign ack_leaf_ev = (st_q == WS_LEAF) && mem_ack;
  assign ack_wb_ev   = (st_q == WS_WB)   && mem_ack;

  logic [1:0]     leaf_fault;
  logic [E_W-1:0] leaf_new;
  logic           leaf_changed;

  ptw_perm_check #(.E_W(E_W)) u_perm (
    .entry (mem_rdata),
    .acc   (acc_q),
    .fault (leaf_fault)
  );

  ptw_pte_update #(.E_W(E_W)) u_upd (
    .entry     (mem_rdata),
    .acc       (acc_q),
    .entry_new (leaf_new),
    .changed   (leaf_changed)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= WS_IDLE;
      va_q    <= '0;
      acc_q   <= '0;
      root_q  <= '0;
      pde_q   <= '0;
      pte_q   <= '0;
      pa_q    <= '0;
      fault_q <= FLT_NONE;
      nc_q    <= 1'b0;
    end else begin
      case (st_q)
        WS_IDLE: if (accept_ev) begin
          va_q    <= req_va;
          acc_q   <= req_acc;
          root_q  <= root_base;
          pa_q    <= '0;
          fault_q <= FLT_NONE;
          nc_q    <= 1'b0;
          st_q    <= WS_DIR;
        end
        WS_DIR: if (mem_ack) begin
          pde_q <= mem_rdata;
          if (!mem_rdata[FLG_VALID]) begin
            fault_q <= FLT_PAGE;
            st_q    <= WS_RSP;
          end else begin
            st_q <= WS_LEAF;
          end
        end
        WS_LEAF: if (mem_ack) begin
          if (leaf_fault != FLT_NONE) begin
            fault_q <= leaf_fault;
            st_q    <= WS_RSP;
          end else begin
            pa_q  <= make_pa(mem_rdata, va_q);
            nc_q  <= mem_rdata[FLG_NC];
            pte_q <= leaf_new;
            st_q  <= leaf_changed ? WS_WB : WS_RSP;
          end
        end
        WS_WB: if (mem_ack) st_q <= WS_RSP;
        WS_RSP: st_q <= WS_IDLE;
        default: st_q <= WS_IDLE;
      endcase
    end
  end

  always_comb begin
    case (st_q)
      WS_DIR:  mem_addr = dir_word(root_q, va_q);
      WS_LEAF: mem_addr = leaf_word(pde_q, va_q);
      WS_WB:   mem_addr = leaf_word(pde_q, va_q);
      default: mem_addr = '0;
    endcase
  end

  assign mem_rd_req  = (st_q == WS_DIR) || (st_q == WS_LEAF);
  assign mem_wr_req  = (st_q == WS_WB);
  assign mem_wdata   = pte_q;
  assign req_ready   = (st_q == WS_IDLE);
  assign rsp_valid   = (st_q == WS_RSP);
  assign rsp_pa      = pa_q;
  assign rsp_fault   = fault_q;
  assign rsp_nocache = nc_q;

  // R8
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R8
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ev |=> (mem_rd_req && !req_ready));

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && !mem_ack) |=> (mem_rd_req && $stable(mem_addr)));

  // R9
  one_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_req && mem_wr_req));

  // R4
  fault_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != FLT_NONE) |-> (rsp_pa == '0 && !rsp_nocache));

  // R7
  wb_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_req |-> mem_wdata[FLG_REF]);

  // R6
  offset_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == FLT_NONE) |-> (rsp_pa[OFF_W-1:0] == va_q[OFF_W-1:0]));

  // R4
  no_wb_after_dir_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_dir_ev && !mem_rdata[FLG_VALID]) |=> (rsp_valid && !mem_rd_req));
endmodule

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
  localparam logic [31:0] ROOT = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] root_base = ROOT;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic [1:0]  req_acc = '0;
  logic        rsp_valid;
  logic [31:0] rsp_pa;
  logic [1:0]  rsp_fault;
  logic        rsp_nocache;
  logic        mem_rd_req, mem_wr_req;
  logic [29:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;

  pt_walker u_dut (
    .clk(clk), .rst_n(rst_n), .root_base(root_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va), .req_acc(req_acc),
    .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault), .rsp_nocache(rsp_nocache),
    .mem_rd_req(mem_rd_req), .mem_wr_req(mem_wr_req), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  always #2.5 clk = ~clk;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  // memory model
  logic [31:0] mem [0:4095];
  int lat = 0;
  int cnt = 0;
  int rd_n = 0;
  int wr_n = 0;
  int rsp_n = 0;
  int hold_err = 0;
  logic [29:0] rd_log [0:63];
  logic [29:0] wr_addr_last = '0;
  logic [31:0] wr_data_last = '0;
  logic [29:0] prev_addr = '0;
  logic        prev_pend = 1'b0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rsp_valid) rsp_n <= rsp_n + 1;
    if (mem_rd_req && mem_wr_req) hold_err <= hold_err + 1;
    if (prev_pend && (mem_rd_req || mem_wr_req) && mem_addr != prev_addr) hold_err <= hold_err + 1;
    prev_pend <= (mem_rd_req || mem_wr_req) && !mem_ack;
    prev_addr <= mem_addr;
    if (!rst_n) begin
      mem_ack <= 1'b0;
      cnt <= 0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
    end else if (mem_rd_req || mem_wr_req) begin
      if (cnt == lat) begin
        mem_ack <= 1'b1;
        cnt <= 0;
        if (mem_rd_req) begin
          mem_rdata <= mem[mem_addr[11:0]];
          rd_log[rd_n % 64] <= mem_addr;
          rd_n <= rd_n + 1;
        end else begin
          mem[mem_addr[11:0]] <= mem_wdata;
          wr_addr_last <= mem_addr;
          wr_data_last <= mem_wdata;
          wr_n <= wr_n + 1;
        end
      end else begin
        cnt <= cnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_va(int d, int t, int off);
    return {d[9:0], t[9:0], off[11:0]};
  endfunction

  // expected word addresses, restated as multiplications
  function automatic logic [29:0] e_dir(logic [31:0] va);
    return 30'(ROOT / 4 + va[31:22]);
  endfunction
  function automatic logic [29:0] e_leaf(logic [31:0] pde, logic [31:0] va);
    return 30'((pde >> 12) * 1024 + va[21:12]);
  endfunction

  logic [31:0] g_pa;
  logic [1:0]  g_flt;
  logic        g_nc;
  int          g_rd0, g_wr0;

  task automatic walk(input logic [31:0] va, input logic [1:0] acc);
    g_rd0 = rd_n;
    g_wr0 = wr_n;
    @(negedge clk);
    req_valid = 1'b1; req_va = va; req_acc = acc;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 300; i++) begin
      if (rsp_valid) break;
      @(negedge clk);
    end
    if (!rsp_valid) chk(1'b0, "timeout waiting response", 0, 1);
    g_pa = rsp_pa; g_flt = rsp_fault; g_nc = rsp_nocache;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1, "R10 ready", 32'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R10 rsp_valid", 32'(rsp_valid), 0);
    chk(mem_rd_req == 1'b0 && mem_wr_req == 1'b0, "R10 mem idle", {mem_rd_req, mem_wr_req}, 0);
  endtask

  task automatic t_read_ok();
    logic [31:0] va = mk_va(3, 5, 12'hABC);
    lat = 0;
    walk(va, 2'd0);
    chk(g_flt == 2'd0, "R6 read fault", 32'(g_flt), 0);
    chk(g_pa == 32'h12345ABC, "R6 read pa", g_pa, 32'h12345ABC);
    chk(g_nc == 1'b0, "R6 read nocache", 32'(g_nc), 0);
    chk(rd_n - g_rd0 == 2, "R3 two reads", rd_n - g_rd0, 2);
    chk(rd_log[g_rd0 % 64] == e_dir(va), "R1 dir addr", 32'(rd_log[g_rd0 % 64]), 32'(e_dir(va)));
    chk(rd_log[(g_rd0 + 1) % 64] == e_leaf(32'h0000_2001, va), "R2 leaf addr",
        32'(rd_log[(g_rd0 + 1) % 64]), 32'(e_leaf(32'h0000_2001, va)));
    chk(wr_n - g_wr0 == 1, "R7 ref write count", wr_n - g_wr0, 1);
    chk(wr_data_last == 32'h12345013, "R7 ref set", wr_data_last, 32'h12345013);
    chk(wr_addr_last == e_leaf(32'h0000_2001, va), "R7 wb addr", 32'(wr_addr_last),
        32'(e_leaf(32'h0000_2001, va)));
  endtask

  task automatic t_read_again();
    walk(mk_va(3, 5, 12'h004), 2'd0);
    chk(g_pa == 32'h12345004, "R6 repeat pa", g_pa, 32'h12345004);
    chk(wr_n - g_wr0 == 0, "R7 no write when unchanged", wr_n - g_wr0, 0);
  endtask

  task automatic t_write();
    walk(mk_va(3, 6, 12'h010), 2'd1);
    chk(g_flt == 2'd0, "R6 write fault", 32'(g_flt), 0);
    chk(g_pa == 32'hABCDE010, "R6 write pa", g_pa, 32'hABCDE010);
    chk(wr_n - g_wr0 == 1, "R7 mod write count", wr_n - g_wr0, 1);
    chk(wr_data_last == 32'hABCDE037, "R7 mod set", wr_data_last, 32'hABCDE037);
  endtask

  task automatic t_exec_nc();
    lat = 3;
    walk(mk_va(7, 1, 12'hFFF), 2'd2);
    chk(g_flt == 2'd0, "R6 exec fault", 32'(g_flt), 0);
    chk(g_pa == 32'h00F0FFFF, "R6 exec pa", g_pa, 32'h00F0FFFF);
    chk(g_nc == 1'b1, "R6 exec nocache", 32'(g_nc), 1);
    chk(wr_data_last == 32'h00F0F059, "R7 exec ref only", wr_data_last, 32'h00F0F059);
  endtask

  task automatic t_dir_invalid();
    lat = 1;
    walk(mk_va(9, 2, 12'h123), 2'd0);
    chk(g_flt == 2'd1, "R4 dir fault", 32'(g_flt), 1);
    chk(g_pa == 32'h0, "R4 dir pa", g_pa, 0);
    chk(rd_n - g_rd0 == 1, "R4 one read", rd_n - g_rd0, 1);
    chk(wr_n - g_wr0 == 0, "R4 no write", wr_n - g_wr0, 0);
  endtask

  task automatic t_leaf_invalid();
    walk(mk_va(3, 7, 12'h222), 2'd0);
    chk(g_flt == 2'd1, "R4 leaf fault", 32'(g_flt), 1);
    chk(g_pa == 32'h0 && g_nc == 1'b0, "R4 leaf pa/nc", g_pa, 0);
    chk(wr_n - g_wr0 == 0, "R4 leaf no write", wr_n - g_wr0, 0);
  endtask

  task automatic t_prot();
    walk(mk_va(3, 5, 12'h100), 2'd1);
    chk(g_flt == 2'd2, "R5 write on ro", 32'(g_flt), 2);
    chk(g_pa == 32'h0, "R5 pa zero", g_pa, 0);
    chk(wr_n - g_wr0 == 0, "R5 no write", wr_n - g_wr0, 0);
    walk(mk_va(3, 5, 12'h100), 2'd2);
    chk(g_flt == 2'd2, "R5 exec on noexec", 32'(g_flt), 2);
    walk(mk_va(3, 5, 12'h100), 2'd3);
    chk(g_flt == 2'd2, "R5 reserved access", 32'(g_flt), 2);
    chk(mem[12'h805] == 32'h12345013, "R5 entry untouched", mem[12'h805], 32'h12345013);
  endtask

  task automatic t_busy();
    int r0 = rsp_n;
    lat = 3;
    g_rd0 = rd_n;
    @(negedge clk);
    req_valid = 1'b1; req_va = mk_va(3, 6, 12'h055); req_acc = 2'd0;
    @(negedge clk);
    req_va = mk_va(9, 0, 0); req_acc = 2'd1;
    chk(req_ready == 1'b0, "R8 busy not ready", 32'(req_ready), 0);
    @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 300; i++) begin
      if (rsp_valid) break;
      @(negedge clk);
    end
    chk(rsp_pa == 32'hABCDE055 && rsp_fault == 2'd0, "R8 first request kept", rsp_pa, 32'hABCDE055);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R8 pulse one cycle", 32'(rsp_valid), 0);
    repeat (20) @(negedge clk);
    chk(rsp_n - r0 == 1, "R8 busy request ignored", rsp_n - r0, 1);
    chk(rd_n - g_rd0 == 2, "R8 no extra reads", rd_n - g_rd0, 2);
    chk(hold_err == 0, "R9 stable and exclusive", hold_err, 0);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
    mem[12'h403] = 32'h0000_2001;
    mem[12'h407] = 32'h0000_3001;
    mem[12'h409] = 32'h0000_3000;
    mem[12'h805] = 32'h1234_5003;
    mem[12'h806] = 32'hABCD_E017;
    mem[12'h807] = 32'hFFFF_F0FE;
    mem[12'hC01] = 32'h00F0_F049;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_ok();
    t_read_again();
    t_write();
    t_exec_nc();
    t_dir_invalid();
    t_leaf_invalid();
    t_prot();
    t_busy();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (cyc > 20000);
    tests++;
    fails++;
    $display("FAIL watchdog actual=%0d expected<20000", cyc);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule